// File: doc/BRIEF.md
# Unbuffered Serial Shift Register

This block is an 8-bit register that serves at once as the host-visible data register and as the serial shift stage. There is no staging copy: a host write lands directly in the shift stages, and the read port always shows the live contents. Every shift moves the contents one place toward the most significant bit, and the serial input bit enters at bit 0.

A 2-bit source select chooses what triggers a shift. It can be a software strobe, a pulse from a timer compare match, or a rising or falling edge of an external serial clock. The external clock and the external data input pass through a synchronizer into the system clock domain before edge detection. A host write in the same cycle as a shift trigger takes priority, so the written value is kept and no shift takes place.

The serial output is taken from the top bit through a latch. With an internal source selected, the latch is always transparent. With an external source selected, it is transparent only during the half of the serial clock period that follows the output edge. As a result, input sampling and output updates fall on opposite serial clock edges.

Top module: `ser_shift_reg`

## Requirements
- R1: While reset is asserted, the register reads 0x00 and the serial output is 0.
- R2: The read port returns the register contents directly, so a written value is visible in the cycle after the write.
- R3: When a host write and a shift trigger occur in the same cycle, the register takes the written value and does not shift.
- R4: With source select 2'b00, each cycle with the software strobe high shifts the register left by one and loads the serial input into bit 0.
- R5: With source select 2'b01, each cycle with the compare-match pulse high shifts the register left by one and loads the serial input into bit 0.
- R6: With source select 2'b10, each rising edge of the external serial clock causes exactly one shift. The shift takes effect three system clocks after the edge (two synchronizer stages plus the register), whatever the length of the high phase.
- R7: With source select 2'b11, each falling edge of the external serial clock causes exactly one shift, with the same latency as R6. Rising edges do not shift.
- R8: With source select 2'b00 or 2'b01, the serial output always equals bit 7 of the register, including straight after a host write.
- R9: With source select 2'b10, the output latch is closed while the synchronized serial clock is high. With 2'b11, it is closed while that clock is low. While the latch is closed, the serial output holds the last bit 7 seen while it was open, even if bit 7 is rewritten. While it is open, the output follows bit 7.
- R10: Trigger inputs of a source that is not selected have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Shift source: 00 strobe, 01 compare match, 10 external rising edge, 11 external falling edge |
| host_wr_en | input | 1 | Host write enable |
| host_wr_data | input | 8 | Host write data |
| host_rd_data | output | 8 | Live register contents |
| sw_strobe | input | 1 | Software shift strobe |
| cmp_match | input | 1 | Timer compare-match pulse |
| ser_clk_in | input | 1 | External serial clock, asynchronous |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Latched serial data output |

## Verification
The bench builds the block with WIDTH = 8 and SYNC_STAGES = 2. With these values every expected register value can be written as a literal byte, and an external clock edge reaches the register a fixed three system clocks later. That fixed delay lets the bench sample the shift, and the opening and closing of the output latch, on exact cycles. It also lets the bench hold the serial clock high for extra cycles to show that a long phase still produces only one shift, and rewrite bit 7 while the latch is closed to show that the output does not move.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    SRC_STROBE   = 2'b00,
    SRC_TIMER    = 2'b01,
    SRC_EXT_RISE = 2'b10,
    SRC_EXT_FALL = 2'b11
  } shift_src_e;

  function automatic logic src_is_external(shift_src_e s);
    return s[1];
  endfunction

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (i == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_rest
        assign stage_d = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ssr_trigger.sv
module ssr_trigger
  import ssr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  shift_src_e src,
  input  logic       sw_strobe,
  input  logic       cmp_match,
  input  logic       sck_s,
  input  logic       din_raw,
  input  logic       din_s,
  output logic       shift_pulse,
  output logic       shift_bit
);

  logic sck_prev_q;
  logic sck_prev_d;
  logic sck_rise;
  logic sck_fall;

  assign sck_prev_d = sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= sck_prev_d;
  end

  assign sck_rise = sck_s & ~sck_prev_q;
  assign sck_fall = ~sck_s & sck_prev_q;

  always_comb begin
    shift_pulse = 1'b0;
    shift_bit   = din_raw;
    unique case (src)
      SRC_STROBE:   begin shift_pulse = sw_strobe; shift_bit = din_raw; end
      SRC_TIMER:    begin shift_pulse = cmp_match; shift_bit = din_raw; end
      SRC_EXT_RISE: begin shift_pulse = sck_rise;  shift_bit = din_s;   end
      SRC_EXT_FALL: begin shift_pulse = sck_fall;  shift_bit = din_s;   end
      default:      begin shift_pulse = 1'b0;      shift_bit = din_raw; end
    endcase
  end

endmodule

// File: rtl/ssr_out_latch.sv
module ssr_out_latch
  import ssr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  shift_src_e src,
  input  logic       sck_s,
  input  logic       msb,
  output logic       dout,
  output logic       lat_open
);

  logic hold_q;
  logic hold_d;
  logic ext_open;

  // External modes: open in the half period after the output edge,
  // i.e. opposite to the sampling level of the synchronized clock.
  assign ext_open = ~(sck_s ^ src[0]);
  assign lat_open = src_is_external(src) ? ext_open : 1'b1;

  always_comb begin
    hold_d = hold_q;
    if (lat_open) hold_d = msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign dout = lat_open ? msb : hold_q;

endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg
  import ssr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  input  logic             host_wr_en,
  input  logic [WIDTH-1:0] host_wr_data,
  output logic [WIDTH-1:0] host_rd_data,
  input  logic             sw_strobe,
  input  logic             cmp_match,
  input  logic             ser_clk_in,
  input  logic             ser_din,
  output logic             ser_dout
);

  localparam int MSB = WIDTH - 1;

  shift_src_e       src;
  logic [1:0]       sync_q;
  logic             sck_s;
  logic             din_s;
  logic             shift_pulse;
  logic             shift_bit;
  logic             latch_open;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;

  assign src = shift_src_e'(clk_sel);

  ssr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_clk_in, ser_din}),
    .q     (sync_q)
  );

  assign sck_s = sync_q[1];
  assign din_s = sync_q[0];

  ssr_trigger u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .src         (src),
    .sw_strobe   (sw_strobe),
    .cmp_match   (cmp_match),
    .sck_s       (sck_s),
    .din_raw     (ser_din),
    .din_s       (din_s),
    .shift_pulse (shift_pulse),
    .shift_bit   (shift_bit)
  );

  // Host write wins over a coincident shift.
  always_comb begin
    data_d = data_q;
    if (host_wr_en)       data_d = host_wr_data;
    else if (shift_pulse) data_d = {data_q[MSB-1:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign host_rd_data = data_q;

  ssr_out_latch u_olat (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .sck_s    (sck_s),
    .msb      (data_q[MSB]),
    .dout     (ser_dout),
    .lat_open (latch_open)
  );

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       clk_sel,
  input logic             host_wr_en,
  input logic [WIDTH-1:0] host_wr_data,
  input logic [WIDTH-1:0] host_rd_data,
  input logic             sw_strobe,
  input logic             cmp_match,
  input logic             ser_din,
  input logic             ser_dout,
  input logic             latch_open
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (host_rd_data == '0 && ser_dout == 1'b0)); // R1

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en |=> host_rd_data == $past(host_wr_data)); // R3

  AST_STROBE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr_en && clk_sel == 2'b00 && sw_strobe)
      |=> host_rd_data == {$past(host_rd_data[WIDTH-2:0]), $past(ser_din)}); // R4

  AST_TIMER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr_en && clk_sel == 2'b01 && cmp_match)
      |=> host_rd_data == {$past(host_rd_data[WIDTH-2:0]), $past(ser_din)}); // R5

  AST_UNSELECTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr_en && ((clk_sel == 2'b00 && !sw_strobe) || (clk_sel == 2'b01 && !cmp_match)))
      |=> $stable(host_rd_data)); // R10

  AST_INTERNAL_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel[1] |-> ser_dout == host_rd_data[WIDTH-1]); // R8

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[1] && !latch_open && $past(clk_sel[1]) && !$past(latch_open))
      |-> $stable(ser_dout)); // R9

endmodule

bind ser_shift_reg ssr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_sel      (clk_sel),
  .host_wr_en   (host_wr_en),
  .host_wr_data (host_wr_data),
  .host_rd_data (host_rd_data),
  .sw_strobe    (sw_strobe),
  .cmp_match    (cmp_match),
  .ser_din      (ser_din),
  .ser_dout     (ser_dout),
  .latch_open   (latch_open)
);

// File: tb/ser_shift_reg_tb.sv
`timescale 1ns/1ps
module ser_shift_reg_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   clk_sel;
  logic         host_wr_en;
  logic [W-1:0] host_wr_data;
  logic [W-1:0] host_rd_data;
  logic         sw_strobe;
  logic         cmp_match;
  logic         ser_clk_in;
  logic         ser_din;
  logic         ser_dout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ser_shift_reg #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel      (clk_sel),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .host_rd_data (host_rd_data),
    .sw_strobe    (sw_strobe),
    .cmp_match    (cmp_match),
    .ser_clk_in   (ser_clk_in),
    .ser_din      (ser_din),
    .ser_dout     (ser_dout)
  );

  typedef struct packed {
    logic [1:0]   sel;
    logic         wr;
    logic [W-1:0] wd;
    logic         stb;
    logic         cmp;
    logic         din;
    logic [W-1:0] exp_data;
    logic         exp_dout;
  } vec_t;

  // One cycle per row; expected register and output after the edge.
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1}, // R2 write
    '{2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h4B, 1'b0}, // R4 strobe
    '{2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h96, 1'b1}, // R4 strobe
    '{2'b00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h96, 1'b1}, // R10 cmp ignored
    '{2'b01, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h2D, 1'b0}, // R5 compare
    '{2'b01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h2D, 1'b0}, // R10 strobe ignored
    '{2'b01, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0}, // R3 write over compare
    '{2'b00, 1'b1, 8'h81, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1}, // R3 R8 write over strobe
    '{2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02, 1'b0}, // R4 R8
    '{2'b01, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0}  // R10 idle
  };

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic idle_inputs();
    host_wr_en = 1'b0; sw_strobe = 1'b0; cmp_match = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_sel = 2'b00; host_wr_data = '0; ser_clk_in = 1'b0; ser_din = 1'b0;
    idle_inputs();
    #1;
    check("R1 data in reset", host_rd_data, 8'h00);
    check("R1 dout in reset", {7'd0, ser_dout}, 8'h00);
    tick(2);
    rst_n = 1'b1;
    tick(1);

    for (int v = 0; v < NV; v++) begin
      clk_sel = VECS[v].sel; host_wr_en = VECS[v].wr; host_wr_data = VECS[v].wd;
      sw_strobe = VECS[v].stb; cmp_match = VECS[v].cmp; ser_din = VECS[v].din;
      tick(1);
      check($sformatf("R2 R3 R4 R5 R10 vec %0d data", v), host_rd_data, VECS[v].exp_data);
      check($sformatf("R8 vec %0d dout", v), {7'd0, ser_dout}, {7'd0, VECS[v].exp_dout});
    end
    idle_inputs();

    // R6 / R9: external rising edge mode
    clk_sel = 2'b10; host_wr_en = 1'b1; host_wr_data = 8'h80; ser_din = 1'b1;
    tick(1);
    host_wr_en = 1'b0;
    check("R9 open follows msb", {7'd0, ser_dout}, 8'h01);
    ser_clk_in = 1'b1;
    tick(2);
    check("R6 no shift before sync latency", host_rd_data, 8'h80);
    tick(1);
    check("R6 one shift on rising edge", host_rd_data, 8'h01);
    check("R9 closed keeps old msb", {7'd0, ser_dout}, 8'h01);
    tick(3);
    check("R6 long high phase single shift", host_rd_data, 8'h01);
    host_wr_en = 1'b1; host_wr_data = 8'h7F;
    tick(1);
    host_wr_en = 1'b0;
    check("R2 write while closed", host_rd_data, 8'h7F);
    check("R9 msb rewrite hidden while closed", {7'd0, ser_dout}, 8'h01);
    ser_clk_in = 1'b0;
    tick(2);
    check("R9 reopened follows msb", {7'd0, ser_dout}, 8'h00);
    tick(1);
    check("R6 falling edge no shift", host_rd_data, 8'h7F);

    // R7 / R9: external falling edge mode
    clk_sel = 2'b11; ser_clk_in = 1'b1; ser_din = 1'b1;
    tick(3);
    check("R7 rising edge no shift", host_rd_data, 8'h7F);
    check("R9 open while high in fall mode", {7'd0, ser_dout}, 8'h00);
    ser_clk_in = 1'b0;
    tick(3);
    check("R7 falling edge shifts", host_rd_data, 8'hFF);
    check("R9 closed while low holds", {7'd0, ser_dout}, 8'h00);
    ser_clk_in = 1'b1;
    tick(2);
    check("R9 opens on high", {7'd0, ser_dout}, 8'h01);

    // R1: reset in the middle of operation
    tick(1);
    rst_n = 1'b0;
    #1;
    check("R1 async clear data", host_rd_data, 8'h00);
    check("R1 async clear dout", {7'd0, ser_dout}, 8'h00);
    tick(1);
    rst_n = 1'b1;
    tick(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule